// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the slave side of a two-wire serial bus in front of a byte-wide memory held inside the design as a synchronous RAM. It oversamples SCL and SDA with the system clock, finds START and STOP conditions, and decodes a control byte. That byte holds a 4-bit device type, the upper word-address bits and a read/write flag. A write selection is followed by a word-address byte and then data bytes. A read selection streams bytes out for as long as the master keeps acknowledging them.

An address pointer survives from one transaction to the next. This gives three kinds of read: a current-address read (no address phase), a random read (an address-only write, a repeated START, then a read selection) and a sequential read that walks the whole array. Every received data byte is also reported on a one-cycle strobe to a separate page-programming unit. While that unit signals that it is busy, the slave ignores every START, so the master can poll until an acknowledge comes back. SCL must be at least eight times slower than the system clock.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset, and whenever no transfer is selected, the block does not pull SDA low and `wr_stb_o` stays low.
- R2: START is SDA falling while SCL is high; STOP is SDA rising while SCL is high. After a START, a control byte whose bits [7:4] equal 4'b1010 (MSB first) is acknowledged by SDA held low through the ninth clock. Any other device type gets no acknowledge, and the block then stays silent until the next START.
- R3: In a write (control bit 0 = 0), the word address becomes {control bits [ADDR_W-8:1], address byte}. Each data byte is acknowledged and stored at the pointer. It is also reported as one `wr_stb_o` pulse carrying that address and the data.
- R4: In a read (control bit 0 = 1), bytes go out MSB first. Each master acknowledge (SDA low on the ninth clock) makes the block send the next byte. The pointer advances across all ADDR_W bits and wraps from the last location to 0.
- R5: A read with no preceding address phase returns the byte at the last accessed address plus one.
- R6: An address-only write, then a repeated START and a read control byte, returns the byte at the loaded address first.
- R7: During a write, the pointer increments only its low PAGE_W bits after each data byte, so writing past the end of a page wraps to the start of the same page.
- R8: While `busy_i` is high, a START is ignored and the control byte that follows gets no acknowledge. Once `busy_i` is low again, a new START is acknowledged normally.
- R9: In a read control byte, bits [3:1] are ignored.
- R10: When the master does not acknowledge a read byte, the block stops driving SDA, and further clocks return all ones until the next START.
- R11: A START in the middle of any byte drops the current transfer and restarts control-byte reception.
- R12: The block changes what it drives on SDA only after an SCL falling edge, a START or a STOP, so SDA is stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 = pull SDA low (acknowledge or a data zero) |
| busy_i | input | 1 | Programming cycle in progress; START is ignored |
| wr_stb_o | output | 1 | One-cycle pulse per received data byte |
| wr_addr_o | output | ADDR_W | Address of the reported data byte |
| wr_data_o | output | 8 | Reported data byte |

## Verification
The bench builds the block with ADDR_W = 9 and PAGE_W = 4, a 512-byte array of 32 sixteen-byte pages. This size lets it write every location and then read the whole array back in one sequential read. That read starts mid-array, so it crosses the wrap from the last location to zero. Expected bytes come from an arithmetic pattern over the address. Page rollover, busy polling, current-address and don't-care reads, NACK termination and a START inside a byte are each driven at a known pointer value.

// File: rtl/twi_mem_pkg.sv
`timescale 1ns/1ps
package twi_mem_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_ADDR,
      ST_WDATA,
      ST_ACK,
      ST_RDATA,
      ST_RACK,
      ST_WAIT
   } twi_st_e;
endpackage

// File: rtl/twi_sync.sv
`timescale 1ns/1ps
module twi_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("twi_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/twi_mem_ram.sv
`timescale 1ns/1ps
module twi_mem_ram #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/twi_addr_ctr.sv
`timescale 1ns/1ps
module twi_addr_ctr #(
   parameter int ADDR_W = 11,
   parameter int PAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc_page,
   input  logic              inc_all,
   output logic [ADDR_W-1:0] ptr
);
   logic [ADDR_W-1:0] page_next;

   generate
      if (PAGE_W < 1) begin : g_bad_page
         $error("PAGE_W must be at least 1");
      end
      if (PAGE_W >= ADDR_W) begin : g_flat
         assign page_next = ptr + 1'b1;
      end else begin : g_paged
         logic [PAGE_W-1:0] low_inc;
         assign low_inc   = ptr[PAGE_W-1:0] + 1'b1;
         assign page_next = {ptr[ADDR_W-1:PAGE_W], low_inc};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)           ptr <= '0;
      else if (load)     ptr <= load_val;
      else if (inc_all)  ptr <= ptr + 1'b1;
      else if (inc_page) ptr <= page_next;
   end

   // R4: full-width increment wraps from the last location to zero
   assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (inc_all && !load && ptr == '1) |=> (ptr == '0));

   // R7: a write increment keeps the page bits
   assert_page_kept_R7: assert property (@(posedge clk) disable iff (rst)
      (inc_page && !inc_all && !load) |=>
         (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));
endmodule

// File: rtl/twi_mem_slave.sv
`timescale 1ns/1ps
module twi_mem_slave
   import twi_mem_pkg::*;
#(
   parameter int         ADDR_W      = 11,
   parameter int         PAGE_W      = 4,
   parameter logic [3:0] DEV_ID      = 4'b1010,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic              busy_i,
   output logic              wr_stb_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o
);
   localparam int HI_W = ADDR_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 11) begin : g_bad_addr
         $error("ADDR_W must lie between 9 and 11");
      end
   endgenerate

   // ---------------- bus sampling ----------------
   logic scl_s, sda_s, scl_q, sda_q;

   twi_sync #(.STAGES(SYNC_STAGES)) i_scl_sync (.clk(clk), .rst(rst), .d_i(scl_i), .q_o(scl_s));
   twi_sync #(.STAGES(SYNC_STAGES)) i_sda_sync (.clk(clk), .rst(rst), .d_i(sda_i), .q_o(sda_s));

   always_ff @(posedge clk) begin
      if (rst) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   logic scl_rise, scl_fall, bus_start, bus_stop;
   assign scl_rise  =  scl_s && !scl_q;
   assign scl_fall  = !scl_s &&  scl_q;
   assign bus_start =  scl_s &&  scl_q &&  sda_q && !sda_s;
   assign bus_stop  =  scl_s &&  scl_q && !sda_q &&  sda_s;

   // ---------------- protocol state ----------------
   twi_st_e           st, ack_nx;
   logic [3:0]        bit_cnt;
   logic [7:0]        rx_sh, tx_sh;
   logic [HI_W-1:0]   hi_pend;
   logic              m_ack;

   logic [ADDR_W-1:0] ptr;
   logic [7:0]        rd_byte;
   logic              byte_end, ctr_load, inc_page, inc_all, ram_we;

   assign byte_end = scl_fall && (bit_cnt == 4'd8);

   always_comb begin
      ctr_load = 1'b0;
      inc_page = 1'b0;
      inc_all  = 1'b0;
      ram_we   = 1'b0;
      if (!bus_start && !bus_stop) begin
         unique case (st)
            ST_ADDR:  ctr_load = byte_end;
            ST_WDATA: begin
               ram_we   = byte_end;
               inc_page = byte_end;
            end
            ST_ACK:   inc_all = scl_fall && (ack_nx == ST_RDATA);
            ST_RACK:  inc_all = scl_fall && m_ack;
            default:  ;
         endcase
      end
   end

   twi_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_ctr (
      .clk(clk), .rst(rst), .load(ctr_load), .load_val({hi_pend, rx_sh}),
      .inc_page(inc_page), .inc_all(inc_all), .ptr(ptr)
   );

   twi_mem_ram #(.AW(ADDR_W), .DW(8)) i_ram (
      .clk(clk), .we(ram_we), .waddr(ptr), .wdata(rx_sh),
      .raddr(ptr), .rdata(rd_byte)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st      <= ST_IDLE;
         ack_nx  <= ST_IDLE;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '1;
         hi_pend <= '0;
         m_ack   <= 1'b0;
      end else if (bus_start) begin
         st      <= busy_i ? ST_IDLE : ST_CTRL;
         bit_cnt <= '0;
      end else if (bus_stop) begin
         st <= ST_IDLE;
      end else begin
         unique case (st)
            ST_CTRL, ST_ADDR, ST_WDATA: begin
               if (scl_rise) begin
                  rx_sh   <= {rx_sh[6:0], sda_s};
                  bit_cnt <= bit_cnt + 4'd1;
               end
               if (byte_end) begin
                  bit_cnt <= '0;
                  if (st == ST_CTRL) begin
                     if (rx_sh[7:4] == DEV_ID) begin
                        st     <= ST_ACK;
                        ack_nx <= rx_sh[0] ? ST_RDATA : ST_ADDR;
                        if (!rx_sh[0]) hi_pend <= rx_sh[HI_W:1];
                     end else begin
                        st <= ST_WAIT;
                     end
                  end else begin
                     st     <= ST_ACK;
                     ack_nx <= ST_WDATA;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  st      <= ack_nx;
                  bit_cnt <= '0;
                  if (ack_nx == ST_RDATA) tx_sh <= rd_byte;
               end
            end
            ST_RDATA: begin
               if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
               if (scl_fall) begin
                  if (bit_cnt == 4'd8) begin
                     st      <= ST_RACK;
                     bit_cnt <= '0;
                  end else begin
                     tx_sh <= {tx_sh[6:0], 1'b1};
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) m_ack <= !sda_s;
               if (scl_fall) begin
                  if (m_ack) begin
                     st      <= ST_RDATA;
                     tx_sh   <= rd_byte;
                     bit_cnt <= '0;
                  end else begin
                     st <= ST_WAIT;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe_o = (st == ST_ACK) || ((st == ST_RDATA) && !tx_sh[7]);

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_stb_o  <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         wr_stb_o <= ram_we;
         if (ram_we) begin
            wr_addr_o <= ptr;
            wr_data_o <= rx_sh;
         end
      end
   end

   // R1: nothing is driven while no transfer is selected
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      (st == ST_IDLE || st == ST_WAIT) |-> !sda_oe_o);

   // R2: a STOP releases the line in the following cycle
   assert_stop_release_R2: assert property (@(posedge clk) disable iff (rst)
      bus_stop |=> !sda_oe_o);

   // R8: a START while busy leaves the slave unselected
   assert_busy_ignored_R8: assert property (@(posedge clk) disable iff (rst)
      (bus_start && busy_i) |=> (st == ST_IDLE && !sda_oe_o));

   // R12: the driven level only moves after SCL falls, a START or a STOP
   assert_sda_moves_on_fall_R12: assert property (@(posedge clk) disable iff (rst)
      !$stable(sda_oe_o) |-> $past(scl_fall || bus_start || bus_stop));

   // R3: report strobes are single-cycle
   assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
      wr_stb_o |=> !wr_stb_o);
endmodule

// File: tb/test_twi_mem_slave.sv
`timescale 1ns/1ps
module test_twi_mem_slave;
   localparam int AW    = 9;
   localparam int PW    = 4;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          scl = 1'b1;
   logic          msda = 1'b1;
   logic          busy = 1'b0;
   logic          sda_oe, wr_stb;
   logic [AW-1:0] wr_addr;
   logic [7:0]    wr_data;
   logic          sda_line;

   assign sda_line = msda & ~sda_oe;

   always #10 clk = ~clk;

   twi_mem_slave #(.ADDR_W(AW), .PAGE_W(PW), .DEV_ID(4'b1010), .SYNC_STAGES(2)) i_twi_mem_slave (
      .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
      .busy_i(busy), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
   );

   int         chk_n  = 0;
   int         fail_n = 0;
   logic [7:0] exp_mem [DEPTH];
   logic [AW-1:0] last_wa;
   logic [7:0]    last_wd;

   always @(negedge clk) begin
      if (wr_stb) begin
         last_wa = wr_addr;
         last_wd = wr_data;
      end
   end

   function automatic logic [7:0] pat(int a);
      int v;
      v = (a * 37 + 11) ^ (a >> 3);
      return v[7:0];
   endfunction

   function automatic logic [7:0] ctrl_w(int a);
      logic [AW-1:0] aa;
      aa = AW'(a);
      return {4'b1010, 2'b00, aa[8], 1'b0};
   endfunction

   task automatic check(input logic ok, input string what, input int act, input int exp);
      chk_n++;
      if (!ok) begin
         fail_n++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      wclk(3); msda = 1'b1; wclk(3); scl = 1'b1; wclk(3); msda = 1'b0; wclk(3); scl = 1'b0;
   endtask

   task automatic bus_stop();
      wclk(3); msda = 1'b0; wclk(3); scl = 1'b1; wclk(3); msda = 1'b1; wclk(3);
   endtask

   task automatic bit_out(input logic b);
      wclk(3); msda = b; wclk(3); scl = 1'b1; wclk(6); scl = 1'b0;
   endtask

   task automatic bit_in(output logic b, output logic steady);
      logic s1, s2;
      wclk(3); msda = 1'b1; wclk(3); scl = 1'b1;
      wclk(1); s1 = sda_line;
      wclk(3); b = sda_line;
      wclk(2); s2 = sda_line;
      scl = 1'b0;
      steady = (s1 == b) && (s2 == b);
   endtask

   task automatic byte_out(input logic [7:0] d, output logic acked);
      logic b, st;
      for (int i = 7; i >= 0; i--) bit_out(d[i]);
      bit_in(b, st);
      acked = !b;
   endtask

   task automatic byte_in(output logic [7:0] d, input logic give_ack, output logic steady);
      logic b, st;
      steady = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         bit_in(b, st);
         d[i] = b;
         steady = steady & st;
      end
      bit_out(!give_ack);
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", chk_n - fail_n, chk_n);
      $finish;
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      chk_n++;
      fail_n++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      finish_up();
   end

   initial begin
      logic       ack, steady;
      logic [7:0] d;
      int         a;

      wclk(5);
      rst = 1'b0;
      wclk(2);
      check(sda_oe == 1'b0, "R1 reset sda release", sda_oe, 0);
      check(wr_stb == 1'b0, "R1 reset strobe low", wr_stb, 0);

      // R2: wrong device type is not acknowledged
      bus_start();
      byte_out(8'hB0, ack);
      check(!ack, "R2 foreign device type", ack, 0);
      bus_stop();

      // R3: fill the whole array page by page
      for (int p = 0; p < DEPTH / 16; p++) begin
         bus_start();
         byte_out(ctrl_w(p * 16), ack);
         check(ack, "R2 control byte ack", ack, 1);
         byte_out(8'((p * 16) & 255), ack);
         check(ack, "R3 address ack", ack, 1);
         for (int k = 0; k < 16; k++) begin
            a = p * 16 + k;
            byte_out(pat(a), ack);
            exp_mem[a] = pat(a);
            check(ack, "R3 data ack", ack, 1);
            check(last_wa == AW'(a) && last_wd == pat(a), "R3 write report",
                  {last_wa, last_wd}, {a[AW-1:0], pat(a)});
         end
         bus_stop();
      end

      // R7: page rollover within page 0x40..0x4F
      bus_start();
      byte_out(ctrl_w(9'h04C), ack);
      byte_out(8'h4C, ack);
      for (int k = 0; k < 6; k++) begin
         a = 9'h040 + ((12 + k) % 16);
         byte_out(8'hA0 + 8'(k), ack);
         exp_mem[a] = 8'hA0 + 8'(k);
         check(last_wa == AW'(a), "R7 page rollover address", last_wa, a);
      end
      bus_stop();
      check(sda_oe == 1'b0, "R1 idle after stop", sda_oe, 0);

      // R8: polling while busy
      busy = 1'b1;
      bus_start();
      byte_out(ctrl_w(0), ack);
      check(!ack, "R8 no ack while busy", ack, 0);
      bus_stop();
      busy = 1'b0;
      bus_start();
      byte_out(ctrl_w(0), ack);
      check(ack, "R8 ack after busy clears", ack, 1);
      bus_stop();

      // R6 random read at 0x105, then R4 sequential sweep across the wrap
      bus_start();
      byte_out(ctrl_w(9'h105), ack);
      byte_out(8'h05, ack);
      bus_start();
      byte_out(8'hA1, ack);
      check(ack, "R6 read control ack", ack, 1);
      for (int i = 0; i < DEPTH; i++) begin
         a = (9'h105 + i) % DEPTH;
         byte_in(d, i != DEPTH - 1, steady);
         if (i == 0) check(d == exp_mem[a], "R6 random read first byte", d, exp_mem[a]);
         else        check(d == exp_mem[a], "R4 sequential read byte", d, exp_mem[a]);
         check(steady, "R12 sda stable while scl high", steady, 1);
      end
      // R10: after the NACK the slave stays silent
      byte_in(d, 1'b0, steady);
      check(d == 8'hFF, "R10 silent after nack", d, 8'hFF);
      bus_stop();

      // R5: current address read continues after the last byte (0x104)
      bus_start();
      byte_out(8'hA1, ack);
      byte_in(d, 1'b0, steady);
      check(d == exp_mem[9'h105], "R5 current address read", d, exp_mem[9'h105]);
      bus_stop();

      // R9: upper bits of a read control byte ignored
      bus_start();
      byte_out(8'hAF, ack);
      check(ack, "R9 read control with upper bits set", ack, 1);
      byte_in(d, 1'b0, steady);
      check(d == exp_mem[9'h106], "R9 upper bits ignored", d, exp_mem[9'h106]);
      bus_stop();

      // R11: START inside a byte restarts control reception
      bus_start();
      bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
      bus_start();
      byte_out(8'hA1, ack);
      check(ack, "R11 control ack after aborted byte", ack, 1);
      byte_in(d, 1'b0, steady);
      check(d == exp_mem[9'h107], "R11 read after abort", d, exp_mem[9'h107]);
      bus_stop();
      wclk(4);
      check(sda_oe == 1'b0 && wr_stb == 1'b0, "R1 idle at end", sda_oe, 0);

      finish_up();
   end
endmodule